// File: doc/BRIEF.md
# Branch Trace History Buffer

This block keeps a short, newest-first record of the branches a processor core has just retired. Each cycle the retire stage may present one branch: its class, the address it left from and the address it went to, and two qualifiers. One qualifier marks a conditional branch whose displacement is zero. The other marks the jump to the reset vector that follows a reset. A branch that passes the class enables and the qualifiers is written as a source/destination pair into an eight-slot ring. When the ring is full, the oldest pair is overwritten.

A debugger reads the ring through a plain index port. Index 0 is the most recent capture. A slot that holds nothing yet reads as zero, with the valid flag low.

In continuous mode the ring does not wrap silently. The write that fills it raises a pause request. The core is expected to halt retirement until the debugger has read the ring out and pulsed the drain acknowledge. This happens for at most four fills, so 32 branches in all, and after that capture wraps again. The retire interface has no ready signal. Its only back-pressure is the pause request. Any branch presented while the pause request is high is dropped, so the core must honour it.

Top module: `brtrace_hist`

## Requirements
- R1: An accepted branch is visible at readout index 0 in the cycle after the clock edge that captured it. Index k returns the k-th older capture. The entry count saturates at 8, and further captures overwrite the oldest pair.
- R2: Class code 0 is normal (jumps and conditional branches), 1 is subroutine (call and return), 2 is exception (exception return and all exception or interrupt entries). Code 3 is reserved and is never recorded.
- R3: Enable bit n of `cap_en` gates capture of class n (bit 0 normal, bit 1 subroutine, bit 2 exception). A branch whose class is disabled leaves the buffer unchanged.
- R4: A normal-class branch presented with `ret_disp_zero` high is not recorded. The flag has no effect on the subroutine and exception classes.
- R5: A branch presented with `ret_rstvec` high is not recorded, whatever its class.
- R6: A readout index equal to or above the entry count returns `rd_valid` low and all-zero addresses.
- R7: In continuous mode, the capture that makes the count reach 8 raises `pause_req` from the next cycle on. While it is high, branches are ignored, and it stays high until `drain_ack`.
- R8: `drain_ack` while `pause_req` is high clears `pause_req` and empties the buffer (count 0) at that clock edge.
- R9: After four drains, continuous mode raises no further pause request and the buffer wraps as in R1. Clearing `cont_mode` re-arms the drain counter.
- R10: After reset the entry count is 0, `pause_req` is low and every readout index returns invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A branch retires this cycle |
| ret_class | input | 2 | Branch class code (R2) |
| ret_src | input | AW | Address of the branch instruction |
| ret_dst | input | AW | Address the branch went to |
| ret_disp_zero | input | 1 | Conditional branch with zero displacement |
| ret_rstvec | input | 1 | Jump to the reset vector caused by reset |
| cap_en | input | 3 | Per-class capture enables |
| cont_mode | input | 1 | Continuous (pause-on-full) mode |
| drain_ack | input | 1 | Debugger has emptied the buffer |
| pause_req | output | 1 | Request to halt retirement |
| rd_idx | input | log2(DEPTH) | Readout index, 0 = newest |
| rd_valid | output | 1 | Indexed slot holds a capture |
| rd_src | output | AW | Source address at the index |
| rd_dst | output | AW | Destination address at the index |
| hist_cnt | output | log2(DEPTH+1) | Number of valid entries |

## Verification
The bench targets the wrap point. A pointer that is off by one would return the wrong pair at index 0 or index 7 after eleven captures, and a count that does not saturate would make stale slots read as valid. The filter cases are aimed at two mistakes: a design that applies the zero-displacement flag to every class would lose a subroutine return, and one that indexes the enables with the reserved code would record it. In continuous mode the bench checks four points. A pause raised one capture early or late shows in the count. A buffer that keeps accepting while paused changes index 0. A drain that does not empty leaves the count at 8. A drain counter that never stops would raise a fifth pause.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  typedef enum logic [1:0] {
    BRC_NORMAL = 2'd0,
    BRC_CALL   = 2'd1,
    BRC_EXC    = 2'd2,
    BRC_RSVD   = 2'd3
  } br_class_e;

  localparam int unsigned NUM_CLASSES = 3;
endpackage

// File: rtl/brtrace_filter.sv
module brtrace_filter
  import brtrace_pkg::*;
(
  input  logic                   valid,
  input  logic [1:0]             cls,
  input  logic                   disp_zero,
  input  logic                   rstvec,
  input  logic [NUM_CLASSES-1:0] en,
  input  logic                   hold,
  output logic                   accept
);
  logic class_ok;

  always_comb begin
    unique case (br_class_e'(cls))
      BRC_NORMAL: class_ok = en[0] && !disp_zero;
      BRC_CALL:   class_ok = en[1];
      BRC_EXC:    class_ok = en[2];
      default:    class_ok = 1'b0;
    endcase
  end

  assign accept = valid && class_ok && !rstvec && !hold;
endmodule

// File: rtl/brtrace_store.sv
module brtrace_store #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_src,
  input  logic [AW-1:0]              wr_dst,
  input  logic                       flush,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic                       rd_valid,
  output logic [AW-1:0]              rd_src,
  output logic [AW-1:0]              rd_dst,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       near_full
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_ONE  = PW'(1);
  localparam logic [CW-1:0] C_ONE  = CW'(1);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] C_LAST = CW'(DEPTH - 1);

  logic [PW-1:0] wptr;
  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];
  logic [PW-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else if (wr_en) begin
      wptr <= wptr + P_ONE;
      if (cnt != C_FULL) cnt <= cnt + C_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_q[wptr] <= wr_src;
      dst_q[wptr] <= wr_dst;
    end
  end

  assign near_full = (cnt >= C_LAST);
  assign slot      = wptr - rd_idx - P_ONE;
  assign rd_valid  = CW'(rd_idx) < cnt;
  assign rd_src    = rd_valid ? src_q[slot] : '0;
  assign rd_dst    = rd_valid ? dst_q[slot] : '0;
endmodule

// File: rtl/brtrace_pace.sv
module brtrace_pace #(
  parameter int unsigned MAX_DRAINS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cont_mode,
  input  logic wr_en,
  input  logic near_full,
  input  logic drain_ack,
  output logic pause,
  output logic flush
);
  localparam int unsigned DCW = $clog2(MAX_DRAINS + 1);
  localparam logic [DCW-1:0] D_MAX = DCW'(MAX_DRAINS);
  localparam logic [DCW-1:0] D_ONE = DCW'(1);

  logic [DCW-1:0] drains;

  always_ff @(posedge clk) begin
    if (!rst_n || !cont_mode) begin
      pause  <= 1'b0;
      drains <= '0;
    end else if (pause && drain_ack) begin
      pause  <= 1'b0;
      drains <= drains + D_ONE;
    end else if (wr_en && near_full && drains < D_MAX) begin
      pause <= 1'b1;
    end
  end

  assign flush = cont_mode && pause && drain_ack;
endmodule

// File: rtl/brtrace_hist.sv
module brtrace_hist
  import brtrace_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned MAX_DRAINS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ret_valid,
  input  logic [1:0]                 ret_class,
  input  logic [AW-1:0]              ret_src,
  input  logic [AW-1:0]              ret_dst,
  input  logic                       ret_disp_zero,
  input  logic                       ret_rstvec,
  input  logic [NUM_CLASSES-1:0]     cap_en,
  input  logic                       cont_mode,
  input  logic                       drain_ack,
  output logic                       pause_req,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic                       rd_valid,
  output logic [AW-1:0]              rd_src,
  output logic [AW-1:0]              rd_dst,
  output logic [$clog2(DEPTH+1)-1:0] hist_cnt
);
  logic accept;
  logic near_full;
  logic flush;

  brtrace_filter u_filter (
    .valid     (ret_valid),
    .cls       (ret_class),
    .disp_zero (ret_disp_zero),
    .rstvec    (ret_rstvec),
    .en        (cap_en),
    .hold      (pause_req),
    .accept    (accept)
  );

  brtrace_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept),
    .wr_src    (ret_src),
    .wr_dst    (ret_dst),
    .flush     (flush),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_src    (rd_src),
    .rd_dst    (rd_dst),
    .cnt       (hist_cnt),
    .near_full (near_full)
  );

  brtrace_pace #(.MAX_DRAINS(MAX_DRAINS)) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .cont_mode (cont_mode),
    .wr_en     (accept),
    .near_full (near_full),
    .drain_ack (drain_ack),
    .pause     (pause_req),
    .flush     (flush)
  );
endmodule

// File: rtl/brtrace_hist_chk.sv
module brtrace_hist_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned MAX_DRAINS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ret_rstvec,
  input logic                       cont_mode,
  input logic                       drain_ack,
  input logic                       pause_req,
  input logic                       rd_valid,
  input logic [AW-1:0]              rd_src,
  input logic [AW-1:0]              rd_dst,
  input logic [$clog2(DEPTH+1)-1:0] hist_cnt
);
  int unsigned rises;
  logic        pause_d;

  always_ff @(posedge clk) begin
    if (!rst_n || !cont_mode) begin
      rises   <= 0;
      pause_d <= 1'b0;
    end else begin
      pause_d <= pause_req;
      if (pause_req && !pause_d) rises <= rises + 1;
    end
  end

  assert_cnt_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hist_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  assert_gap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_src == '0 && rd_dst == '0));

  assert_rstvec_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_rstvec && !drain_ack) |=> $stable(hist_cnt));

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !drain_ack && cont_mode) |=> pause_req);

  assert_pause_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> hist_cnt == ($clog2(DEPTH+1))'(DEPTH));

  assert_drain_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && drain_ack && cont_mode) |=> (hist_cnt == '0 && !pause_req));

  assert_drain_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rises <= MAX_DRAINS);
endmodule

bind brtrace_hist brtrace_hist_chk #(.AW(AW), .DEPTH(DEPTH), .MAX_DRAINS(MAX_DRAINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ret_rstvec (ret_rstvec),
  .cont_mode  (cont_mode),
  .drain_ack  (drain_ack),
  .pause_req  (pause_req),
  .rd_valid   (rd_valid),
  .rd_src     (rd_src),
  .rd_dst     (rd_dst),
  .hist_cnt   (hist_cnt)
);

// File: tb/brtrace_hist_tb.sv
`timescale 1ns/1ps
module brtrace_hist_tb;
  localparam int unsigned AW = 32;
  localparam logic [31:0] MASK = 32'h5A5A_0000;

  // {valid, class[1:0], disp_zero, rstvec, expect_accept, src[31:0]}
  localparam logic [37:0] VEC [10] = '{
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_1000},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_2000},
    {1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0000_3000},
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_4000},
    {1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0000_5000},
    {1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_6000},
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_7000},
    {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_8000},
    {1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_9000},
    {1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0000_A000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ret_valid = 1'b0;
  logic [1:0]    ret_class = '0;
  logic [AW-1:0] ret_src = '0;
  logic [AW-1:0] ret_dst = '0;
  logic          ret_disp_zero = 1'b0;
  logic          ret_rstvec = 1'b0;
  logic [2:0]    cap_en = 3'b111;
  logic          cont_mode = 1'b0;
  logic          drain_ack = 1'b0;
  logic          pause_req;
  logic [2:0]    rd_idx = '0;
  logic          rd_valid;
  logic [AW-1:0] rd_src;
  logic [AW-1:0] rd_dst;
  logic [3:0]    hist_cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  brtrace_hist u_dut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_class(ret_class),
    .ret_src(ret_src), .ret_dst(ret_dst), .ret_disp_zero(ret_disp_zero),
    .ret_rstvec(ret_rstvec), .cap_en(cap_en), .cont_mode(cont_mode),
    .drain_ack(drain_ack), .pause_req(pause_req), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_src(rd_src), .rd_dst(rd_dst), .hist_cnt(hist_cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic v, input logic [1:0] c, input logic [31:0] s,
                      input logic dz, input logic rv);
    @(negedge clk);
    ret_valid = v; ret_class = c; ret_src = s; ret_dst = s ^ MASK;
    ret_disp_zero = dz; ret_rstvec = rv;
    @(negedge clk);
    ret_valid = 1'b0; ret_disp_zero = 1'b0; ret_rstvec = 1'b0;
  endtask

  task automatic look(input logic [2:0] idx);
    rd_idx = idx;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    look(3'd0);
    chk("R10 cnt", 64'(hist_cnt), 64'd0);
    chk("R10 pause", 64'(pause_req), 64'd0);
    chk("R10 valid", 64'(rd_valid), 64'd0);

    // Table walk: classes, qualifiers, enables all on
    exp_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      string tag;
      logic [37:0] v;
      v = VEC[i];
      if (v[36:35] == 2'd3)      tag = "R2";
      else if (v[33])            tag = "R5";
      else if (v[34])            tag = "R4";
      else                       tag = "R1";
      push(v[37], v[36:35], v[31:0], v[34], v[33]);
      if (v[32]) exp_cnt++;
      look(3'd0);
      chk(tag, 64'(hist_cnt), 64'(exp_cnt));
      if (v[32]) begin
        chk(tag, 64'(rd_src), 64'(v[31:0]));
        chk(tag, 64'(rd_dst), 64'(v[31:0] ^ MASK));
      end
    end

    // R3: per-class enables
    do_reset();
    cap_en = 3'b010;
    push(1'b1, 2'd0, 32'h0000_0040, 1'b0, 1'b0);
    chk("R3 normal disabled", 64'(hist_cnt), 64'd0);
    push(1'b1, 2'd2, 32'h0000_0048, 1'b0, 1'b0);
    chk("R3 exception disabled", 64'(hist_cnt), 64'd0);
    push(1'b1, 2'd1, 32'h0000_0050, 1'b0, 1'b0);
    look(3'd0);
    chk("R3 call enabled", 64'(hist_cnt), 64'd1);
    chk("R3 call src", 64'(rd_src), 64'h50);
    cap_en = 3'b111;

    // R1: wrap and saturation
    for (int k = 0; k < 10; k++) push(1'b1, 2'd0, 32'h100 + k, 1'b0, 1'b0);
    look(3'd0);
    chk("R1 saturate", 64'(hist_cnt), 64'd8);
    chk("R1 newest src", 64'(rd_src), 64'h109);
    chk("R1 newest dst", 64'(rd_dst), 64'(32'h109 ^ MASK));
    look(3'd7);
    chk("R1 oldest src", 64'(rd_src), 64'h102);
    chk("R1 oldest valid", 64'(rd_valid), 64'd1);

    // R6: index beyond count
    do_reset();
    for (int k = 0; k < 3; k++) push(1'b1, 2'd1, 32'h200 + k, 1'b0, 1'b0);
    look(3'd3);
    chk("R6 valid", 64'(rd_valid), 64'd0);
    chk("R6 src", 64'(rd_src), 64'd0);
    chk("R6 dst", 64'(rd_dst), 64'd0);
    look(3'd2);
    chk("R1 index2", 64'(rd_src), 64'h200);

    // R7/R8: continuous mode, four fills
    do_reset();
    cont_mode = 1'b1;
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 8; k++) begin
        push(1'b1, 2'd0, 32'h1000 * (f + 1) + k, 1'b0, 1'b0);
        if (k == 6) chk("R7 no early pause", 64'(pause_req), 64'd0);
      end
      look(3'd0);
      chk("R7 pause on fill", 64'(pause_req), 64'd1);
      chk("R7 full", 64'(hist_cnt), 64'd8);
      push(1'b1, 2'd1, 32'h0000_DEAD, 1'b0, 1'b0);
      look(3'd0);
      chk("R7 ignored while paused", 64'(rd_src), 64'(32'h1000 * (f + 1) + 7));
      repeat (2) @(negedge clk);
      chk("R7 pause held", 64'(pause_req), 64'd1);
      drain_ack = 1'b1;
      @(negedge clk);
      drain_ack = 1'b0;
      look(3'd0);
      chk("R8 pause cleared", 64'(pause_req), 64'd0);
      chk("R8 emptied", 64'(hist_cnt), 64'd0);
    end

    // R9: drain limit reached, buffer wraps
    for (int k = 0; k < 9; k++) push(1'b1, 2'd2, 32'h9000 + k, 1'b0, 1'b0);
    look(3'd0);
    chk("R9 no fifth pause", 64'(pause_req), 64'd0);
    chk("R9 count", 64'(hist_cnt), 64'd8);
    chk("R9 wrap newest", 64'(rd_src), 64'h9008);

    // R9: clearing the mode re-arms the drain counter
    cont_mode = 1'b0;
    @(negedge clk);
    cont_mode = 1'b1;
    push(1'b1, 2'd2, 32'h0000_9100, 1'b0, 1'b0);
    chk("R9 re-armed pause", 64'(pause_req), 64'd1);
    cont_mode = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule